// File: doc/BRIEF.md
# Sixteen-Pin Edge-Interrupt GPIO Bank

This block controls one bank of sixteen general-purpose pins behind a small synchronous register bus. Software chooses the direction of each pin, drives output levels, reads synchronized input levels, and picks which pin edges raise an interrupt. Each pin can trigger on a rising edge, a falling edge, both edges or no edge. Triggering is edge-only. The bus has no level-sensitive mode.

The output-data, interrupt-enable and wake-enable masks each have two extra alias addresses, one that sets bits and one that clears them. Bits written as one change and bits written as zero are left alone, so no read-modify-write is needed. Latched edges collect in a write-one-to-clear status register. Two combined outputs are built from it: a bank interrupt line and a wake request line.

Top module: `pinbank16`

## Requirements
- R1: After reset, direction reads 0xFFFF (all pins inputs, `pin_oe` = 0). Output data, interrupt enable, wake enable, both trigger registers and status read 0. `irq` and `wake` are low. The revision word at 0x00 reads {major[7:4], minor[3:0]}, which is 0x0010 by default.
- R2: The following registers read back what was last written: configuration at 0x10, output data at 0x30, direction at 0x34, interrupt enable at 0x1C and wake enable at 0x28. The system status word at 0x14 reads 0x0001. `pin_out` equals output data, and `pin_oe` is the inverse of direction (a direction bit of 1 means input).
- R3: Input data at 0x2C returns the pin levels after a two-flop synchronizer. A change driven before clock edge k is readable after edge k+1 and not after edge k.
- R4: Writing to 0xF0 sets the output-data bits that are written as one. Writing to 0xB0 clears them. Bits written as zero are unchanged.
- R5: Writing to 0xDC sets interrupt-enable bits and writing to 0x9C clears them. Writing to 0xE8 sets wake-enable bits and writing to 0xA8 clears them. Bits written as zero are unchanged.
- R6: Each pin has a 2-bit trigger field. Bit 1 of the field enables rising edges and bit 0 enables falling edges, so 11 means both edges and 00 means none. Pins 0–7 are held in 0x38 and pins 8–15 in 0x3C. Pin n within its half uses bits [2n+1:2n].
- R7: A status bit latches when its selected edge occurs, whether or not its interrupt is enabled. Writing ones to 0x18 clears the matching bits, and writing 0xFFFF clears all of them.
- R8: `irq` is high exactly when some status bit has its interrupt-enable bit set.
- R9: `wake` is high exactly when some status bit has its wake-enable bit set.
- R10: If a clear write to status lands in the same cycle as a new selected edge on that pin, the bit stays set.
- R11: A pin held at a steady level does not set its status bit again after the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven output levels |
| pin_oe | output | 16 | Output enable per pin |
| irq | output | 1 | Bank interrupt |
| wake | output | 1 | Wake request |

## Verification
The edge logic is tried with a single pattern in which four low-half pins carry the four trigger codes and one high-half pin carries a rising code. Both directions of transition are applied to that pattern. A swapped rise/fall bit, a wrong half-split or a dead "none" code each produces a different status word. Separate sequences cover the following:
- masked versus unmasked latching;
- partial versus full status clears;
- a clear that collides with a fresh edge in the same cycle;
- a pin held high after its status has been cleared, which exposes any level sensitivity.

Alias writes use mixed one/zero masks, so that an alias that overwrites the register is told apart from one that only sets or only clears bits.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam logic [7:0] A_REV      = 8'h00;
    localparam logic [7:0] A_CFG      = 8'h10;
    localparam logic [7:0] A_SYSST    = 8'h14;
    localparam logic [7:0] A_STAT     = 8'h18;
    localparam logic [7:0] A_IEN      = 8'h1C;
    localparam logic [7:0] A_WEN      = 8'h28;
    localparam logic [7:0] A_DIN      = 8'h2C;
    localparam logic [7:0] A_DOUT     = 8'h30;
    localparam logic [7:0] A_DIR      = 8'h34;
    localparam logic [7:0] A_TRIG_LO  = 8'h38;
    localparam logic [7:0] A_TRIG_HI  = 8'h3C;
    localparam logic [7:0] A_IEN_CLR  = 8'h9C;
    localparam logic [7:0] A_WEN_CLR  = 8'hA8;
    localparam logic [7:0] A_DOUT_CLR = 8'hB0;
    localparam logic [7:0] A_IEN_SET  = 8'hDC;
    localparam logic [7:0] A_WEN_SET  = 8'hE8;
    localparam logic [7:0] A_DOUT_SET = 8'hF0;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_ANY  = 2'b11
    } trig_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    // True when the observed transition is one the field selects.
    function automatic logic edge_hit(trig_e t, pin_edge_t e);
        return (t[1] & e.rise) | (t[0] & e.fall);
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int NPINS  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] din,
    output logic [NPINS-1:0] sample,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    logic [NPINS-1:0] pipe [STAGES];
    logic [NPINS-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
            prev <= '0;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign sample = pipe[STAGES-1];

    for (genvar i = 0; i < NPINS; i++) begin : g_edge
        assign rise[i] = sample[i] & ~prev[i];
        assign fall[i] = ~sample[i] & prev[i];
    end

endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
    import pinbank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    input  logic [NPINS-1:0] trig_lo,
    input  logic [NPINS-1:0] trig_hi,
    input  logic [NPINS-1:0] clr_mask,
    input  logic [NPINS-1:0] ien,
    input  logic [NPINS-1:0] wen,
    output logic [NPINS-1:0] status,
    output logic             irq,
    output logic             wake
);
    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] armed;
    logic [NPINS-1:0] status_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [1:0] fld;
        pin_edge_t  ev;
        if (i < HALF) begin : g_lo
            assign fld = trig_lo[2*i +: 2];
        end else begin : g_hi
            assign fld = trig_hi[2*(i-HALF) +: 2];
        end
        assign ev       = '{rise: rise[i], fall: fall[i]};
        assign hit[i]   = edge_hit(trig_e'(fld), ev);
        assign armed[i] = |fld;
    end

    // A fresh edge outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | hit;
    end

    assign status = status_q;
    assign irq    = |(status_q & ien);
    assign wake   = |(status_q & wen);

    assert_edge_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (|clr_mask) |=> ((status_q & $past(clr_mask & ~hit)) == '0));

    assert_edge_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (|(clr_mask & hit)) |=> ((status_q & $past(clr_mask & hit)) == $past(clr_mask & hit)));

    assert_no_trigger_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(armed)) == '0));

endmodule

// File: rtl/pinbank16.sv
module pinbank16
    import pinbank_pkg::*;
#(
    parameter int         DW        = 16,
    parameter logic [3:0] REV_MAJOR = 4'd1,
    parameter logic [3:0] REV_MINOR = 4'd0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe,
    output logic          irq,
    output logic          wake
);
    localparam logic [DW-1:0] REV_WORD   = {{(DW-8){1'b0}}, REV_MAJOR, REV_MINOR};
    localparam logic [DW-1:0] SYS_READY  = DW'(1);

    logic [DW-1:0] cfg_q, dir_q, dout_q, ien_q, wen_q, trig_lo_q, trig_hi_q;
    logic [DW-1:0] din_s, rise, fall, status, clr_mask;

    pinbank_sync #(.NPINS(DW), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(pin_in),
        .sample(din_s), .rise(rise), .fall(fall)
    );

    assign clr_mask = (bus_we && bus_addr == A_STAT) ? bus_wdata : '0;

    pinbank_irq #(.NPINS(DW)) u_irq (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall),
        .trig_lo(trig_lo_q), .trig_hi(trig_hi_q), .clr_mask(clr_mask),
        .ien(ien_q), .wen(wen_q),
        .status(status), .irq(irq), .wake(wake)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            dir_q     <= '1;
            dout_q    <= '0;
            ien_q     <= '0;
            wen_q     <= '0;
            trig_lo_q <= '0;
            trig_hi_q <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                A_CFG:      cfg_q     <= bus_wdata;
                A_DIR:      dir_q     <= bus_wdata;
                A_DOUT:     dout_q    <= bus_wdata;
                A_DOUT_SET: dout_q    <= dout_q | bus_wdata;
                A_DOUT_CLR: dout_q    <= dout_q & ~bus_wdata;
                A_IEN:      ien_q     <= bus_wdata;
                A_IEN_SET:  ien_q     <= ien_q | bus_wdata;
                A_IEN_CLR:  ien_q     <= ien_q & ~bus_wdata;
                A_WEN:      wen_q     <= bus_wdata;
                A_WEN_SET:  wen_q     <= wen_q | bus_wdata;
                A_WEN_CLR:  wen_q     <= wen_q & ~bus_wdata;
                A_TRIG_LO:  trig_lo_q <= bus_wdata;
                A_TRIG_HI:  trig_hi_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_REV:     bus_rdata = REV_WORD;
            A_CFG:     bus_rdata = cfg_q;
            A_SYSST:   bus_rdata = SYS_READY;
            A_STAT:    bus_rdata = status;
            A_IEN:     bus_rdata = ien_q;
            A_WEN:     bus_rdata = wen_q;
            A_DIN:     bus_rdata = din_s;
            A_DOUT:    bus_rdata = dout_q;
            A_DIR:     bus_rdata = dir_q;
            A_TRIG_LO: bus_rdata = trig_lo_q;
            A_TRIG_HI: bus_rdata = trig_hi_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = ~dir_q;

    assert_set_dout_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_DOUT_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clr_ien_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_IEN_CLR) |=> ((ien_q & $past(bus_wdata)) == '0));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

    assert_wake_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (wen_q == '0) |-> !wake);

endmodule

// File: tb/sim_pinbank16.sv
`timescale 1ns/1ps
module sim_pinbank16;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] pins = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq, wake;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    pinbank16 u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq), .wake(wake)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk); addr = a; we = 1'b1; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(8'h00, v); check("R1 revision", v, 16'h0010);
        rd(8'h34, v); check("R1 direction", v, 16'hFFFF);
        rd(8'h30, v); check("R1 dout", v, 16'h0000);
        rd(8'h1C, v); check("R1 ien", v, 16'h0000);
        rd(8'h18, v); check("R1 status", v, 16'h0000);
        check("R1 oe", pin_oe, 16'h0000);
        check("R1 irq/wake", {14'd0, irq, wake}, 16'h0000);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(8'h34, 16'h00F0);
        rd(8'h34, v); check("R2 direction", v, 16'h00F0);
        check("R2 oe", pin_oe, 16'hFF0F);
        wr(8'h30, 16'hA5A5);
        rd(8'h30, v); check("R2 dout", v, 16'hA5A5);
        check("R2 pin_out", pin_out, 16'hA5A5);
        wr(8'h10, 16'h0014);
        rd(8'h10, v); check("R2 config", v, 16'h0014);
        rd(8'h14, v); check("R2 sysstatus", v, 16'h0001);
    endtask

    task automatic t_din();
        logic [15:0] v;
        @(negedge clk); addr = 8'h2C; pins = 16'h1234;
        @(negedge clk); #1; check("R3 din after one edge", rdata, 16'h0000);
        @(negedge clk); #1; check("R3 din after two edges", rdata, 16'h1234);
        pins = 16'h0000; idle(4);
        rd(8'h2C, v); check("R3 din cleared", v, 16'h0000);
    endtask

    task automatic t_dout_alias();
        logic [15:0] v;
        wr(8'h30, 16'h00FF);
        wr(8'hF0, 16'h0F00);
        rd(8'h30, v); check("R4 set alias", v, 16'h0FFF);
        wr(8'hB0, 16'h00F0);
        rd(8'h30, v); check("R4 clear alias", v, 16'h0F0F);
    endtask

    task automatic t_en_alias();
        logic [15:0] v;
        wr(8'hDC, 16'h8001); wr(8'h9C, 16'h0001);
        rd(8'h1C, v); check("R5 ien alias", v, 16'h8000);
        wr(8'hE8, 16'h0300); wr(8'hA8, 16'h0100);
        rd(8'h28, v); check("R5 wen alias", v, 16'h0200);
        wr(8'h1C, 16'h0000); wr(8'h28, 16'h0000);
    endtask

    task automatic t_edges();
        logic [15:0] v;
        wr(8'h18, 16'hFFFF);
        wr(8'h38, 16'h0036);   // pin0 rise, pin1 fall, pin2 both, pin3 none
        wr(8'h3C, 16'h0008);   // pin9 rise
        @(negedge clk); pins = 16'h020F; idle(4);
        rd(8'h18, v); check("R6 R7 rising pattern", v, 16'h0205);
        check("R8 masked irq", {15'd0, irq}, 16'h0000);
        wr(8'h18, 16'hFFFF);
        rd(8'h18, v); check("R7 clear all", v, 16'h0000);
        @(negedge clk); pins = 16'h0000; idle(4);
        rd(8'h18, v); check("R6 falling pattern", v, 16'h0006);
        wr(8'h18, 16'h0002);
        rd(8'h18, v); check("R7 partial clear", v, 16'h0004);
        wr(8'h18, 16'hFFFF);
    endtask

    task automatic t_irq();
        @(negedge clk); pins[2] = 1'b1; idle(4);
        check("R8 irq low without enable", {15'd0, irq}, 16'h0000);
        wr(8'hDC, 16'h0004);
        check("R8 irq high", {15'd0, irq}, 16'h0001);
        check("R9 wake low", {15'd0, wake}, 16'h0000);
        wr(8'hE8, 16'h0004);
        check("R9 wake high", {15'd0, wake}, 16'h0001);
        wr(8'h9C, 16'h0004);
        check("R8 irq off by enable", {15'd0, irq}, 16'h0000);
        wr(8'h18, 16'hFFFF);
        check("R9 wake off by clear", {15'd0, wake}, 16'h0000);
        wr(8'hA8, 16'hFFFF);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        wr(8'h38, 16'h0336);   // pin4 both edges
        @(negedge clk); pins[4] = 1'b1; idle(4);
        rd(8'h18, v); check("R10 setup", v, 16'h0010);
        @(negedge clk); pins[4] = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = 8'h18; we = 1'b1; wdata = 16'h0010;
        @(negedge clk); we = 1'b0;
        rd(8'h18, v); check("R10 edge beats clear", v, 16'h0010);
        wr(8'h18, 16'hFFFF);
    endtask

    task automatic t_level();
        logic [15:0] v;
        @(negedge clk); pins[0] = 1'b1; idle(4);
        wr(8'h18, 16'hFFFF);
        idle(6);
        rd(8'h18, v); check("R11 steady high", v, 16'h0000);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_din();
        t_dout_alias();
        t_en_alias();
        t_edges();
        t_irq();
        t_collide();
        t_level();
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule